// File: doc/BRIEF.md
# XNOR-Popcount Similarity CAM

This block holds a table of stored hash words and answers similarity queries against it. A write port places a hash word at a row address. A query port takes a hash word and scores every stored row by the number of bit positions in which the row and the query agree, which is the population count of their bitwise XNOR. It then returns the index and the score of the single best row.

The table is scanned `LANES` rows at a time. Each scan beat scores one group of rows in parallel and picks that group's winner. A running best match is updated after every beat. A full scan takes `ceil(NUM_ROWS/LANES)` beats, and the last beat may be only partly filled. The result is offered on a valid/ready handshake and is held until the consumer takes it.

Control is a three-state machine:
- `ST_IDLE` accepts writes and queries. Writes take priority, so a query waits while `wr_valid` is high.
- `ST_SCAN` steps one beat per cycle. Both input ports are closed in this state, so no row changes while it is being scored.
- `ST_HOLD` presents the result. It accepts writes but not queries.

The transitions are:
- `ST_IDLE` to `ST_SCAN` when a query is accepted.
- `ST_SCAN` to `ST_HOLD` after the last beat.
- `ST_HOLD` to `ST_IDLE` when `res_ready` is seen.

Top module: `xnor_cam`

## Requirements
- R1: The reported score equals the number of bit positions in which the query and the winning stored row are equal, that is, the popcount of `~(query ^ row)`.
- R2: A query reports a row whose score is the maximum over all `NUM_ROWS` rows. This holds when the winner lies in a partly filled last beat. `res_idx` is always below `NUM_ROWS`.
- R3: When several rows share the maximum score, the lowest row index is reported. This holds whether the tied rows fall in the same beat or in different beats.
- R4: A row is written only on a rising edge where `wr_valid` and `wr_ready` are both high. Address and data presented with `wr_valid` low change nothing.
- R5: A write whose `wr_addr` is `NUM_ROWS` or above is accepted but changes no row.
- R6: `res_valid` rises exactly `ceil(NUM_ROWS/LANES)` rising edges after the edge that accepted the query, and stays low before that.
- R7: In `ST_SCAN`, `q_ready` and `wr_ready` are both low. In `ST_HOLD`, `q_ready` is low and `wr_ready` is high. In `ST_IDLE`, `wr_ready` is high.
- R8: While `res_valid` is high and `res_ready` is low, `res_idx` and `res_score` hold their values. `res_valid` falls on the edge after `res_ready` is seen high.
- R9: In `ST_IDLE`, `q_ready` is low whenever `wr_valid` is high, so a write and a query are never accepted on the same edge. A query waiting behind a write sees the new row.
- R10: Reset clears every row to zero and clears any pending result. After reset, `res_valid` is low and both ready outputs are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write port can accept |
| wr_addr | input | IDX_W | Row address of the write |
| wr_hash | input | HASH_BITS | Hash word to store |
| q_valid | input | 1 | Query request valid |
| q_ready | output | 1 | Query port can accept |
| q_hash | input | HASH_BITS | Query hash word |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_idx | output | IDX_W | Index of the best row |
| res_score | output | SCORE_W | Matching-bit count of the best row |

## Verification
A wrong running best or a wrong tie decision shows at the ports only when the result is presented. That happens `ceil(NUM_ROWS/LANES)` cycles after the query is accepted, as a wrong `res_idx` or `res_score`. Ties inside one beat and ties across beats are therefore exercised separately, and so is a winner in the partly filled last beat. A machine stuck in the wrong state shows on the very next cycle as a wrong `q_ready`, `wr_ready` or `res_valid`. Those three outputs are compared against the reference model on every clock. A lost or misplaced write stays hidden until a later query scores that row, so every write pattern is followed by a query that targets it.

// File: rtl/xcam_pkg.sv
package xcam_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_HOLD = 2'd2
    } xcam_state_e;
endpackage

// File: rtl/xcam_popcnt.sv
module xcam_popcnt #(
    parameter int W   = 32,
    parameter int GRP = 8,
    parameter int CW  = $clog2(W + 1)
) (
    input  logic [W-1:0]  bits,
    output logic [CW-1:0] count
);
    localparam int NG = (W + GRP - 1) / GRP;
    localparam int GW = $clog2(GRP + 1);

    logic [NG*GW-1:0] part_flat;

    // Each group of GRP bits is counted on its own; the partial counts are added afterwards.
    for (genvar g = 0; g < NG; g++) begin : g_grp
        localparam int LO = g * GRP;
        localparam int HI = (LO + GRP > W) ? W : LO + GRP;
        logic [GW-1:0] cnt_g;
        always_comb begin
            cnt_g = '0;
            for (int b = LO; b < HI; b++) begin
                cnt_g = cnt_g + GW'(bits[b]);
            end
        end
        assign part_flat[g*GW +: GW] = cnt_g;
    end

    always_comb begin
        count = '0;
        for (int g = 0; g < NG; g++) begin
            count = count + CW'(part_flat[g*GW +: GW]);
        end
    end
endmodule

// File: rtl/xcam_rows.sv
module xcam_rows #(
    parameter int ROWS   = 10,
    parameter int HB     = 32,
    parameter int LANES  = 4,
    parameter int AW     = 4,
    parameter int BW     = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [AW-1:0]              waddr,
    input  logic [HB-1:0]              wdata,
    input  logic [BW-1:0]              beat,
    output logic [LANES-1:0][HB-1:0]   lane_rows,
    output logic [LANES-1:0]           lane_ok
);
    logic [HB-1:0] mem [ROWS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                mem[r] <= '0;
            end
        end else if (we && (int'(waddr) < ROWS)) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        int row_i;
        always_comb begin
            row_i = int'(beat) * LANES + l;
            lane_ok[l] = (row_i < ROWS);
            lane_rows[l] = lane_ok[l] ? mem[row_i[AW-1:0]] : '0;
        end
    end
endmodule

// File: rtl/xcam_beat_best.sv
module xcam_beat_best #(
    parameter int LANES = 4,
    parameter int HB    = 32,
    parameter int GRP   = 8,
    parameter int CW    = 6,
    parameter int AW    = 4,
    parameter int BW    = 2
) (
    input  logic [HB-1:0]              query,
    input  logic [LANES-1:0][HB-1:0]   lane_rows,
    input  logic [LANES-1:0]           lane_ok,
    input  logic [BW-1:0]              beat,
    output logic [AW-1:0]              b_idx,
    output logic [CW-1:0]              b_score
);
    logic [LANES-1:0][CW-1:0] lane_score;

    for (genvar l = 0; l < LANES; l++) begin : g_score
        xcam_popcnt #(.W(HB), .GRP(GRP), .CW(CW)) u_pop (
            .bits  (~(query ^ lane_rows[l])),
            .count (lane_score[l])
        );
    end

    // Lowest lane first; a later lane wins only with a strictly greater score.
    always_comb begin
        logic found;
        found   = 1'b0;
        b_idx   = '0;
        b_score = '0;
        for (int l = 0; l < LANES; l++) begin
            if (lane_ok[l] && (!found || (lane_score[l] > b_score))) begin
                found   = 1'b1;
                b_score = lane_score[l];
                b_idx   = AW'(int'(beat) * LANES + l);
            end
        end
    end
endmodule

// File: rtl/xnor_cam.sv
module xnor_cam
    import xcam_pkg::*;
#(
    parameter int NUM_ROWS  = 10,
    parameter int HASH_BITS = 32,
    parameter int LANES     = 4,
    parameter int POP_GROUP = 8,
    parameter int IDX_W     = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
    parameter int SCORE_W   = $clog2(HASH_BITS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_valid,
    output logic                  wr_ready,
    input  logic [IDX_W-1:0]      wr_addr,
    input  logic [HASH_BITS-1:0]  wr_hash,
    input  logic                  q_valid,
    output logic                  q_ready,
    input  logic [HASH_BITS-1:0]  q_hash,
    output logic                  res_valid,
    input  logic                  res_ready,
    output logic [IDX_W-1:0]      res_idx,
    output logic [SCORE_W-1:0]    res_score
);
    localparam int NBEATS = (NUM_ROWS + LANES - 1) / LANES;
    localparam int BEAT_W = (NBEATS > 1) ? $clog2(NBEATS) : 1;

    xcam_state_e state, state_nx;
    logic [BEAT_W-1:0]            beat;
    logic [HASH_BITS-1:0]         q_reg;
    logic [IDX_W-1:0]             best_idx;
    logic [SCORE_W-1:0]           best_score;
    logic [LANES-1:0][HASH_BITS-1:0] lane_rows;
    logic [LANES-1:0]             lane_ok;
    logic [IDX_W-1:0]             beat_idx;
    logic [SCORE_W-1:0]           beat_score;
    logic                         wr_fire, q_fire, last_beat;

    assign wr_fire   = wr_valid && wr_ready;
    assign q_fire    = q_valid && q_ready;
    assign last_beat = (beat == BEAT_W'(NBEATS - 1));

    xcam_rows #(
        .ROWS(NUM_ROWS), .HB(HASH_BITS), .LANES(LANES), .AW(IDX_W), .BW(BEAT_W)
    ) u_rows (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (wr_fire),
        .waddr     (wr_addr),
        .wdata     (wr_hash),
        .beat      (beat),
        .lane_rows (lane_rows),
        .lane_ok   (lane_ok)
    );

    xcam_beat_best #(
        .LANES(LANES), .HB(HASH_BITS), .GRP(POP_GROUP), .CW(SCORE_W),
        .AW(IDX_W), .BW(BEAT_W)
    ) u_best (
        .query     (q_reg),
        .lane_rows (lane_rows),
        .lane_ok   (lane_ok),
        .beat      (beat),
        .b_idx     (beat_idx),
        .b_score   (beat_score)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (q_fire)    state_nx = ST_SCAN;
            ST_SCAN: if (last_beat) state_nx = ST_HOLD;
            ST_HOLD: if (res_ready) state_nx = ST_IDLE;
            default:                state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat       <= '0;
            q_reg      <= '0;
            best_idx   <= '0;
            best_score <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (q_fire) begin
                        q_reg <= q_hash;
                        beat  <= '0;
                    end
                end
                ST_SCAN: begin
                    beat <= last_beat ? '0 : beat + 1'b1;
                    if ((beat == '0) || (beat_score > best_score)) begin
                        best_idx   <= beat_idx;
                        best_score <= beat_score;
                    end
                end
                ST_HOLD: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        wr_ready  = 1'b0;
        q_ready   = 1'b0;
        res_valid = 1'b0;
        unique case (state)
            ST_IDLE: begin
                wr_ready = 1'b1;
                q_ready  = !wr_valid;
            end
            ST_SCAN: ;
            ST_HOLD: begin
                wr_ready  = 1'b1;
                res_valid = 1'b1;
            end
            default: ;
        endcase
    end

    assign res_idx   = best_idx;
    assign res_score = best_score;
endmodule

// File: rtl/xnor_cam_chk.sv
module xnor_cam_chk #(
    parameter int NUM_ROWS  = 10,
    parameter int HASH_BITS = 32,
    parameter int LANES     = 4,
    parameter int IDX_W     = 4,
    parameter int SCORE_W   = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_valid,
    input logic                 wr_ready,
    input logic                 q_valid,
    input logic                 q_ready,
    input logic                 res_valid,
    input logic                 res_ready,
    input logic [IDX_W-1:0]     res_idx,
    input logic [SCORE_W-1:0]   res_score
);
    localparam int NBEATS = (NUM_ROWS + LANES - 1) / LANES;

    logic        scanning;
    logic [15:0] scan_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scanning <= 1'b0;
            scan_cnt <= '0;
        end else if (q_valid && q_ready) begin
            scanning <= 1'b1;
            scan_cnt <= '0;
        end else if (scanning) begin
            if (res_valid) scanning <= 1'b0;
            else           scan_cnt <= scan_cnt + 1'b1;
        end
    end

    p_one_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && wr_ready && q_valid && q_ready));

    p_idle_write_blocks_query_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && !res_valid) |-> !q_ready);

    p_ports_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (scanning && !res_valid) |-> (!q_ready && !wr_ready));

    p_hold_ports_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (!q_ready && wr_ready));

    p_early_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (scanning && (int'(scan_cnt) < NBEATS)) |-> !res_valid);

    p_on_time_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (scanning && (int'(scan_cnt) == NBEATS)) |-> res_valid);

    p_result_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_idx) && $stable(res_score)));

    p_result_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_ready) |=> !res_valid);

    p_index_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (int'(res_idx) < NUM_ROWS));

    p_score_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (int'(res_score) <= HASH_BITS));
endmodule

bind xnor_cam xnor_cam_chk #(
    .NUM_ROWS(NUM_ROWS), .HASH_BITS(HASH_BITS), .LANES(LANES),
    .IDX_W(IDX_W), .SCORE_W(SCORE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .q_valid   (q_valid),
    .q_ready   (q_ready),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_idx   (res_idx),
    .res_score (res_score)
);

// File: tb/xnor_cam_tb_top.sv
module xnor_cam_tb_top;
    localparam int CLK_P = 10;
    localparam int NR    = 10;
    localparam int HB    = 32;
    localparam int LN    = 4;
    localparam int NB    = (NR + LN - 1) / LN;
    localparam int AW    = $clog2(NR);
    localparam int SW    = $clog2(HB + 1);
    localparam int M_IDLE = 0, M_SCAN = 1, M_HOLD = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0, q_valid = 1'b0, res_ready = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [HB-1:0] wr_hash = '0, q_hash = '0;
    logic wr_ready, q_ready, res_valid;
    logic [AW-1:0] res_idx;
    logic [SW-1:0] res_score;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [HB-1:0] m_rows [NR];
    int m_st = M_IDLE;
    int m_cnt = 0;
    int m_idx = 0;
    int m_score = 0;

    always #(CLK_P/2) clk = ~clk;

    xnor_cam #(.NUM_ROWS(NR), .HASH_BITS(HB), .LANES(LN)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_hash(wr_hash),
        .q_valid(q_valid), .q_ready(q_ready), .q_hash(q_hash),
        .res_valid(res_valid), .res_ready(res_ready),
        .res_idx(res_idx), .res_score(res_score)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int score_of(input logic [HB-1:0] a, input logic [HB-1:0] b);
        int s = 0;
        for (int i = 0; i < HB; i++) if (a[i] == b[i]) s++;
        return s;
    endfunction

    task automatic ref_best(input logic [HB-1:0] q, output int bi, output int bs);
        bi = 0;
        bs = -1;
        for (int r = 0; r < NR; r++) begin
            if (score_of(q, m_rows[r]) > bs) begin
                bs = score_of(q, m_rows[r]);
                bi = r;
            end
        end
    endtask

    // Behavioural reference: updated at each edge, compared a quarter period later.
    always @(posedge clk) begin
        bit s_wv, s_qv, s_rr;
        logic [AW-1:0] s_wa;
        logic [HB-1:0] s_wh, s_qh;
        s_wv = wr_valid; s_qv = q_valid; s_rr = res_ready;
        s_wa = wr_addr;  s_wh = wr_hash; s_qh = q_hash;
        if (!rst_n) begin
            for (int r = 0; r < NR; r++) m_rows[r] = '0;
            m_st = M_IDLE;
            m_cnt = 0;
        end else begin
            case (m_st)
                M_IDLE: begin
                    if (s_wv) begin
                        if (int'(s_wa) < NR) m_rows[s_wa] = s_wh;
                    end else if (s_qv) begin
                        ref_best(s_qh, m_idx, m_score);
                        m_cnt = 0;
                        m_st = M_SCAN;
                    end
                end
                M_SCAN: begin
                    m_cnt++;
                    if (m_cnt == NB) m_st = M_HOLD;
                end
                default: begin
                    if (s_wv && int'(s_wa) < NR) m_rows[s_wa] = s_wh;
                    if (s_rr) m_st = M_IDLE;
                end
            endcase
        end
        #(CLK_P/4);
        if (rst_n && !done) begin
            chk(wr_ready == (m_st != M_SCAN), "R7 wr_ready", wr_ready, m_st != M_SCAN);
            chk(q_ready == (m_st == M_IDLE && !wr_valid), "R9 q_ready", q_ready,
                m_st == M_IDLE && !wr_valid);
            chk(res_valid == (m_st == M_HOLD), "R6 res_valid", res_valid, m_st == M_HOLD);
            if (m_st == M_HOLD && res_valid) begin
                chk(int'(res_idx) == m_idx, "R2 R3 res_idx", res_idx, m_idx);
                chk(int'(res_score) == m_score, "R1 res_score", res_score, m_score);
            end
        end
    end

    task automatic write_row(input int a, input logic [HB-1:0] h);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = AW'(a); wr_hash = h;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic run_query(input logic [HB-1:0] q, input int hold, output int gi, output int gs);
        int lat;
        logic [AW-1:0] i0;
        logic [SW-1:0] s0;
        @(negedge clk);
        q_hash = q; q_valid = 1'b1;
        @(negedge clk);
        q_valid = 1'b0;
        lat = 0;
        while (!res_valid) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == NB, "R6 latency", lat, NB);
        i0 = res_idx; s0 = res_score;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            chk(res_valid && res_idx == i0 && res_score == s0, "R8 held", res_idx, i0);
        end
        gi = int'(res_idx); gs = int'(res_score);
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        chk(!res_valid, "R8 taken", res_valid, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        done = 1'b1;
        failures++;
        $display("FAIL watchdog R6 act=hung exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int gi, gs, ei, es;
        logic [HB-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!res_valid && q_ready && wr_ready, "R10 reset outputs", {res_valid, q_ready, wr_ready}, 3'b011);

        // R10: all rows zero after reset, so row 0 wins with the count of zero query bits
        run_query(32'h0000_00FF, 0, gi, gs);
        chk(gi == 0 && gs == 24, "R10 cleared rows", gi * 100 + gs, 24);

        for (int r = 0; r < NR; r++) write_row(r, 32'h1357_9BDF * (r + 3) ^ 32'hF0F0_0F0F);
        // R1 R2: exact match on row 5
        v = 32'h1357_9BDF * 8 ^ 32'hF0F0_0F0F;
        run_query(v, 2, gi, gs);
        chk(gi == 5 && gs == HB, "R1 R2 exact match", gi * 100 + gs, 500 + HB);

        // R2: winner in the partly filled last beat (row 9)
        write_row(9, 32'hDEAD_BEEF);
        run_query(32'hDEAD_BEEE, 0, gi, gs);
        ref_best(32'hDEAD_BEEE, ei, es);
        chk(gi == 9 && gs == 31 && ei == 9, "R2 last beat", gi * 100 + gs, 931);

        // R3: tie across beats (rows 2 and 7)
        write_row(2, 32'hCAFE_0001);
        write_row(7, 32'hCAFE_0001);
        run_query(32'hCAFE_0001, 0, gi, gs);
        chk(gi == 2, "R3 tie across beats", gi, 2);

        // R3: tie inside one beat (rows 4 and 6)
        write_row(4, 32'h7777_1234);
        write_row(6, 32'h7777_1234);
        run_query(32'h7777_1234, 1, gi, gs);
        chk(gi == 4, "R3 tie within beat", gi, 4);

        // R4: address and data shown with wr_valid low
        @(negedge clk);
        wr_addr = AW'(1); wr_hash = 32'h0BAD_F00D;
        repeat (3) @(negedge clk);
        run_query(32'h0BAD_F00D, 0, gi, gs);
        chk(gs != HB, "R4 no write without valid", gs, HB - 1);

        // R5: write to address beyond the table
        write_row(13, 32'hA5A5_5A5A);
        run_query(32'hA5A5_5A5A, 0, gi, gs);
        ref_best(32'hA5A5_5A5A, ei, es);
        chk(gs != HB && gi == ei && gs == es, "R5 out of range write", gs, es);

        // R9: write and query presented together; write first, query sees it
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = AW'(3); wr_hash = 32'h3C3C_C3C3;
        q_valid = 1'b1; q_hash = 32'h3C3C_C3C3;
        #1;
        chk(!q_ready, "R9 q_ready low with write", q_ready, 0);
        @(negedge clk);
        wr_valid = 1'b0;
        @(negedge clk);
        q_valid = 1'b0;
        while (!res_valid) @(negedge clk);
        chk(int'(res_idx) == 3 && int'(res_score) == HB, "R9 query after write", res_idx, 3);
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;

        // R7: write accepted during hold
        @(negedge clk);
        q_hash = 32'h1111_2222; q_valid = 1'b1;
        @(negedge clk);
        q_valid = 1'b0;
        while (!res_valid) @(negedge clk);
        chk(wr_ready && !q_ready, "R7 hold ports", {wr_ready, q_ready}, 2'b10);
        wr_valid = 1'b1; wr_addr = AW'(8); wr_hash = 32'h1111_2222;
        @(negedge clk);
        wr_valid = 1'b0; res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        run_query(32'h1111_2222, 0, gi, gs);
        chk(gi == 8 && gs == HB, "R7 hold write stored", gi, 8);

        // Random patterns against the reference (R1 R2 R3)
        for (int t = 0; t < 20; t++) begin
            for (int r = 0; r < NR; r++) write_row(r, (t % 3 == 0) ? 32'h0F0F_0F0F : $urandom);
            v = (t % 2 == 0) ? $urandom : (m_rows[t % NR] ^ (32'h1 << (t % HB)));
            run_query(v, t % 3, gi, gs);
            ref_best(v, ei, es);
            chk(gi == ei && gs == es, "R1 R2 R3 random", gi * 100 + gs, ei * 100 + es);
        end

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule